// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side read path of a flash memory model while the array is busy. The command decoder and the program/erase timer sit outside it. They report the current operation through a mode code, give bit 7 of the byte being programmed, say whether the read address falls in a sector being erased or suspended for erase, and raise a timeout when an operation has run too long. The array contents come in on a data port. On every read strobe the block decides whether the host sees real array data or a status byte. It also drives a ready/busy line.

The status byte has a data-polling bit, which is the inverted programmed bit or a fixed level. It also has two independent toggle bits, each a flip-flop that inverts on a read only while its own condition holds. The last two fields are a sticky timeout flag and an erase-in-progress bit. Once a timeout is latched, the block keeps reporting the failed operation until a reset command arrives, whatever the mode input does.

Top module: `flash_stat_gen`

## Requirements
- R1: After reset the data output is 0x00 and the ready line is 1.
- R2: Mode codes: 0 array read, 1 program, 2 erase, 3 erase-suspend, 4 suspend-program; codes 5 to 7 act as array read. In array-read mode a read returns the array data input and the ready line is 1.
- R3: Status byte layout: bit 7 poll, bit 6 toggle A, bit 5 timeout, bit 3 erase flag, bit 2 toggle B. In program mode a read returns poll = inverse of the programmed bit 7, bit 5 = 0, bit 3 = 0, toggle B unchanged, and the ready line is 0.
- R4: Both toggle bits are 0 after reset. Toggle A inverts after every read made in program, erase, suspend-program or timed-out state.
- R5: In erase mode a read returns poll = 0, bit 3 = 1 and bit 5 = 0, with the ready line 0. Toggle B inverts on the read only when the sector-hit input is 1.
- R6: In erase-suspend mode with sector hit = 1, a read returns poll = 1, bits 5 and 3 = 0, toggle A unchanged and toggle B inverting. The ready line is 1.
- R7: In erase-suspend mode with sector hit = 0, a read returns array data and the ready line is 1.
- R8: In suspend-program mode a read returns poll = inverse of the programmed bit, bit 5 = 0 and bit 3 = 0, with toggle A inverting. The ready line is 0.
- R9: A timeout seen in program, erase or suspend-program mode latches that operation. Later reads report it with bit 5 = 1 and toggle A inverting, and the ready line stays 0. Changes on the mode or timeout inputs do not release it.
- R10: A reset command clears the latched timeout. Reads then follow the mode input again.
- R11: Bits 4, 1 and 0 of every status byte are 0.
- R12: Data is captured on the clock edge where the read strobe is high and appears after that edge. The output holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| modeIn | input | 3 | Current operation code |
| sectorHit | input | 1 | Read address is in the erasing/suspended sector |
| progBit7 | input | 1 | Bit 7 of the byte being programmed |
| timeout | input | 1 | Operation exceeded its time limit |
| rdEn | input | 1 | One-cycle read strobe |
| resetCmd | input | 1 | Reset command, clears the latched timeout |
| arrayData | input | 8 | Array contents at the read address |
| dataOut | output | 8 | Read data or status byte |
| readyOut | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench targets the two toggle bits across mode changes. A design that flips toggle B in program mode, or flips toggle A during a suspended-sector read, breaks the alternation the bench tracks from reset. Erase reads with the sector-hit input low catch a toggle B that ignores the address. The timeout case changes the mode input to array read before reading, so a design whose timeout flag is not sticky returns array data and the ready line goes high too early. A read after the reset command, and reads in suspend mode with sector hit low, catch a design that keeps reporting status when it should pass array data through.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_PROG     = 3'd1,
    OP_ERASE    = 3'd2,
    OP_SUSPEND  = 3'd3,
    OP_SUSPPROG = 3'd4
  } opMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic showStatus;
    logic flipA;
    logic flipB;
    logic pollBit;
    logic limitBit;
    logic eraseBit;
  } statStb_t;

  function automatic opMode_e decodeMode(input logic [2:0] code);
    case (code)
      3'd1:    return OP_PROG;
      3'd2:    return OP_ERASE;
      3'd3:    return OP_SUSPEND;
      3'd4:    return OP_SUSPPROG;
      default: return OP_READ;
    endcase
  endfunction

  function automatic logic isTimedOp(input opMode_e m);
    return (m == OP_PROG) || (m == OP_ERASE) || (m == OP_SUSPPROG);
  endfunction

endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              sectorHit,
  input  logic              progBit7,
  input  logic              timeout,
  input  logic              rdEn,
  input  logic              resetCmd,
  output statStb_t          stb,
  output logic              readyOut
);

  opMode_e liveMode;
  opMode_e failMode;
  opMode_e effMode;
  logic    failLatched;

  assign liveMode = decodeMode(modeIn[2:0]);
  assign effMode  = failLatched ? failMode : liveMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failLatched <= 1'b0;
      failMode    <= OP_READ;
    end else if (resetCmd) begin
      failLatched <= 1'b0;
      failMode    <= OP_READ;
    end else if (!failLatched && timeout && isTimedOp(liveMode)) begin
      failLatched <= 1'b1;
      failMode    <= liveMode;
    end
  end

  always_comb begin
    stb            = '0;
    stb.load       = rdEn;
    stb.limitBit   = failLatched;
    readyOut       = 1'b1;
    case (effMode)
      OP_PROG, OP_SUSPPROG: begin
        stb.showStatus = 1'b1;
        stb.pollBit    = ~progBit7;
        stb.flipA      = rdEn;
        readyOut       = 1'b0;
      end
      OP_ERASE: begin
        stb.showStatus = 1'b1;
        stb.pollBit    = 1'b0;
        stb.eraseBit   = 1'b1;
        stb.flipA      = rdEn;
        stb.flipB      = rdEn & sectorHit;
        readyOut       = 1'b0;
      end
      OP_SUSPEND: begin
        stb.showStatus = sectorHit;
        stb.pollBit    = 1'b1;
        stb.flipB      = rdEn & sectorHit;
      end
      default: begin
        stb.showStatus = 1'b0;
      end
    endcase
  end

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failLatched && !resetCmd |=> failLatched && readyOut == 1'b0);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> !failLatched);

endmodule

// File: rtl/flash_stat_dp.sv
module flash_stat_dp
  import flash_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStb_t          stb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);

  localparam int POLL_POS  = DATA_W - 1;
  localparam int TOGA_POS  = DATA_W - 2;
  localparam int LIMIT_POS = DATA_W - 3;
  localparam int ERASE_POS = DATA_W - 5;
  localparam int TOGB_POS  = DATA_W - 6;

  logic              togA;
  logic              togB;
  logic [DATA_W-1:0] statusByte;

  always_comb begin
    statusByte            = '0;
    statusByte[POLL_POS]  = stb.pollBit;
    statusByte[TOGA_POS]  = togA;
    statusByte[LIMIT_POS] = stb.limitBit;
    statusByte[ERASE_POS] = stb.eraseBit;
    statusByte[TOGB_POS]  = togB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togA    <= 1'b0;
      togB    <= 1'b0;
      dataOut <= '0;
    end else if (stb.load) begin
      dataOut <= stb.showStatus ? statusByte : arrayData;
      togA    <= togA ^ stb.flipA;
      togB    <= togB ^ stb.flipB;
    end
  end

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(dataOut));

  // R11
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && stb.showStatus |=> dataOut[DATA_W-4] == 1'b0 && dataOut[1:0] == 2'b00);

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import flash_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              sectorHit,
  input  logic              progBit7,
  input  logic              timeout,
  input  logic              rdEn,
  input  logic              resetCmd,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              readyOut
);

  statStb_t stb;

  flash_stat_ctrl #(.MODE_W(MODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .sectorHit(sectorHit),
    .progBit7(progBit7), .timeout(timeout), .rdEn(rdEn),
    .resetCmd(resetCmd), .stb(stb), .readyOut(readyOut)
  );

  flash_stat_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .arrayData(arrayData),
    .dataOut(dataOut)
  );

  // R2
  read_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && !stb.showStatus |=> dataOut == $past(arrayData));

endmodule

// File: tb/flash_stat_gen_tb_top.sv
module flash_stat_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeIn = 3'd0;
  logic       sectorHit = 1'b0;
  logic       progBit7 = 1'b0;
  logic       timeout = 1'b0;
  logic       rdEn = 1'b0;
  logic       resetCmd = 1'b0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] dataOut;
  logic       readyOut;

  int nChecks = 0;
  int nFails  = 0;
  logic eA = 1'b0;
  logic eB = 1'b0;

  always #4 clk = ~clk;

  flash_stat_gen dut_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .sectorHit(sectorHit),
    .progBit7(progBit7), .timeout(timeout), .rdEn(rdEn),
    .resetCmd(resetCmd), .arrayData(arrayData), .dataOut(dataOut),
    .readyOut(readyOut)
  );

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  function automatic logic [7:0] mkStat(logic p, logic a, logic l, logic e, logic b);
    return {p, a, l, 1'b0, e, b, 2'b00};
  endfunction

  task automatic statusRead(input string tag, input logic p, input logic l, input logic e,
                            input logic fA, input logic fB, input logic expRdy);
    logic [7:0] exp;
    exp = mkStat(p, eA, l, e, eB);
    doRead();
    check(dataOut == exp, tag, dataOut, exp);
    check(readyOut == expRdy, {tag, " ready"}, {7'd0, readyOut}, {7'd0, expRdy});
    eA = eA ^ fA;
    eB = eB ^ fB;
  endtask

  task automatic arrayRead(input string tag, input logic [7:0] d);
    arrayData = d;
    doRead();
    check(dataOut == d, tag, dataOut, d);
    check(readyOut == 1'b1, {tag, " ready"}, {7'd0, readyOut}, 8'd1);
  endtask

  task automatic testReset();
    check(dataOut == 8'h00, "R1 data", dataOut, 8'h00);
    check(readyOut == 1'b1, "R1 ready", {7'd0, readyOut}, 8'd1);
  endtask

  task automatic testArray();
    modeIn = 3'd0; arrayRead("R2 read", 8'hA5);
    modeIn = 3'd6; arrayRead("R2 code6", 8'h3C);
    arrayData = 8'h77;
    repeat (3) @(negedge clk);
    check(dataOut == 8'h3C, "R12 hold", dataOut, 8'h3C);
  endtask

  task automatic testProgram();
    modeIn = 3'd1; progBit7 = 1'b1;
    statusRead("R3 R4 R11 prog1", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    progBit7 = 1'b0;
    statusRead("R3 R4 prog2", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testErase();
    modeIn = 3'd2; sectorHit = 1'b1;
    statusRead("R5 erase hit1", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    statusRead("R5 erase hit2", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    sectorHit = 1'b0;
    statusRead("R5 erase miss", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testSuspend();
    modeIn = 3'd3; sectorHit = 1'b1;
    statusRead("R6 susp hit1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    statusRead("R6 susp hit2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    sectorHit = 1'b0;
    arrayRead("R7 susp miss", 8'h5A);
  endtask

  task automatic testSuspProg();
    modeIn = 3'd4; progBit7 = 1'b0;
    statusRead("R8 sprog1", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    progBit7 = 1'b1;
    statusRead("R8 sprog2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testTimeout();
    modeIn = 3'd1; progBit7 = 1'b1;
    @(negedge clk); timeout = 1'b1;
    @(negedge clk); timeout = 1'b0; modeIn = 3'd0;
    statusRead("R9 timeout1", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    statusRead("R9 timeout2", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); resetCmd = 1'b1;
    @(negedge clk); resetCmd = 1'b0;
    arrayRead("R10 after reset", 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testArray();
    testProgram();
    testErase();
    testSuspend();
    testSuspProg();
    testTimeout();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule